// File: doc/BRIEF.md
# Two-Stage Sync-Tip Gain Controller

This block sets the gain of an oversampled composite or luma sample stream so that the depth of the horizontal sync tip below the blanking level matches a programmed target. Gain control has two stages. A coarse loop moves a small analog gain code, sent to an external variable-gain amplifier, by at most one step per line. A fine loop sets an unsigned fixed-point multiplier that scales every incoming 10-bit sample, and the product saturates to the output range.

The depth of the sync tip is measured on every line from a fixed number of samples taken inside a sync-window strobe. The coarse loop uses the depth seen on the raw samples. The fine loop uses the depth seen after the multiplier. When a line reports a white excursion above nominal peak, the target height is lowered, down to a limit, so that bright content fits the range. Lines whose sync tip is too short to fill the measurement give no update. A run of such lines puts the loop into a hold state. The gain found here is also presented as the shared gain for the chroma and colour-difference channels. Each stage has an enable bit; when the bit is low, the stage takes its gain from a manual input.

Top module: `sync_agc`

## Requirements
- R1: While reset is active and after its release, coarse_o is 4 (half the code range), gain_o is 1024 (unity in 2.10 format), hold_o is 0, smp_o is 0 and smp_vld_o is 0.
- R2: One cycle after a sample with smp_vld_i high, smp_o equals min(1023, floor(smp_i*gain_o/1024)), using the gain_o held in that cycle. smp_vld_o repeats smp_vld_i one cycle later. smp_o holds its value after invalid samples.
- R3: With coarse_auto_i high, a valid line end moves coarse_o up one code if the raw depth plus 8 is below the reference, and down one code if the raw depth exceeds the reference plus 8. The code saturates at 0 and 7 and otherwise stays unchanged.
- R4: With fine_auto_i high, a valid line end sets gain_o to gain_o + floor((reference - scaled depth)/4), clamped to 0..4095.
- R5: A depth is the blanking level blank_lvl_i minus the mean of the first 8 samples that have smp_vld_i and sync_win_i high during a line, floored at 0. A line is valid only if it collected 8 such samples. Samples in the cycle of line_end_i are not collected. The scaled depth uses each sample's R2 scaled value.
- R6: The reference is tgt_height_i minus a reduction that starts at 0. A valid, non-held line on which white_ovr_i was high in any cycle, the line-end cycle included, raises the reduction by 16, up to tgt_height_i/2. The new reference applies from the next line.
- R7: When coarse_auto_i is low, coarse_o equals coarse_man_i one cycle later.
- R8: When fine_auto_i is low, gain_o equals fine_man_i one cycle later.
- R9: Each invalid line end while not held counts a miss, saturating at 255. A valid line end clears the count. When the count reaches hold_lines_i, hold_o rises and no update of R3, R4 or R6 occurs. The next valid line end clears hold_o without applying its measurement.
- R10: gain_o is the single gain value used for the luma multiplier and presented for the chroma channels.
- R11: In automatic mode, coarse_o and gain_o change only on the cycle after line_end_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_i | input | 10 | Incoming video sample |
| smp_vld_i | input | 1 | Sample qualifier |
| sync_win_i | input | 1 | High while inside the sync-tip window |
| line_end_i | input | 1 | One-cycle pulse closing a line |
| white_ovr_i | input | 1 | Peak-white excursion flag |
| blank_lvl_i | input | 10 | Blanking level that depths are measured from |
| tgt_height_i | input | 10 | Target sync-tip depth |
| coarse_auto_i | input | 1 | Enables the coarse loop |
| fine_auto_i | input | 1 | Enables the fine loop |
| coarse_man_i | input | 3 | Manual coarse code |
| fine_man_i | input | 12 | Manual fine gain, 2.10 |
| hold_lines_i | input | 8 | Missed lines before hold |
| coarse_o | output | 3 | Analog amplifier gain code |
| smp_o | output | 10 | Scaled, saturated sample |
| smp_vld_o | output | 1 | Qualifier for smp_o |
| gain_o | output | 12 | Fine gain shared with chroma, 2.10 |
| hold_o | output | 1 | Loop held for lack of sync |

## Verification
A wrong sum or sample count in the tip meter does not show at the ports until the next line end. At that point it changes coarse_o or gain_o one cycle after line_end_i, and from the following cycle it changes every scaled sample. A wrong reference reduction or miss count stays hidden longer. It shows only at a later line end, as a gain step of the wrong size or an early or late rise of hold_o. For this reason, the bench model tracks the reduction, the miss count and the accumulators itself, and compares every output on every clock.

// File: rtl/agc_pkg.sv
package agc_pkg;
    // direction chosen by the coarse loop at a line end
    typedef enum logic [1:0] {
        STEP_KEEP = 2'd0,
        STEP_UP   = 2'd1,
        STEP_DOWN = 2'd2
    } step_e;
endpackage

// File: rtl/agc_scale.sv
// Scales one sample by a fixed-point gain and saturates to the sample range.
module agc_scale #(
    parameter int DW   = 10,
    parameter int GW   = 12,
    parameter int FRAC = 10
) (
    input  logic [DW-1:0] smp_i,
    input  logic [GW-1:0] gain_i,
    output logic [DW-1:0] scl_o
);
    localparam int PW = DW + GW;
    localparam logic [PW-FRAC-1:0] LIMIT = PW'((1 << DW) - 1);

    logic [PW-1:0]      prod;
    logic [PW-FRAC-1:0] shifted;

    always_comb begin
        prod    = PW'(smp_i) * PW'(gain_i);
        shifted = prod[PW-1:FRAC];
        if (shifted > LIMIT) begin
            scl_o = '1;
        end else begin
            scl_o = shifted[DW-1:0];
        end
    end
endmodule

// File: rtl/agc_tip_meter.sv
// Collects a fixed count of in-window samples per line and reports depths.
module agc_tip_meter #(
    parameter int DW     = 10,
    parameter int AVG_SH = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          smp_vld_i,
    input  logic          win_i,
    input  logic          line_end_i,
    input  logic [DW-1:0] raw_i,
    input  logic [DW-1:0] scl_i,
    input  logic [DW-1:0] blank_i,
    output logic          full_o,
    output logic [DW-1:0] h_raw_o,
    output logic [DW-1:0] h_scl_o
);
    localparam int SW   = DW + AVG_SH;
    localparam int CNTW = AVG_SH + 1;
    localparam logic [CNTW-1:0] NSMP = CNTW'(1 << AVG_SH);

    typedef struct packed {
        logic [SW-1:0]   sum_raw;
        logic [SW-1:0]   sum_scl;
        logic [CNTW-1:0] cnt;
    } meter_t;

    meter_t m_d, m_q;
    logic [DW-1:0] avg_raw, avg_scl;

    always_comb begin
        m_d = m_q;
        if (line_end_i) begin
            m_d = '0;
        end else if (smp_vld_i && win_i && (m_q.cnt < NSMP)) begin
            m_d.sum_raw = m_q.sum_raw + SW'(raw_i);
            m_d.sum_scl = m_q.sum_scl + SW'(scl_i);
            m_d.cnt     = m_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_q <= '0;
        end else begin
            m_q <= m_d;
        end
    end

    // R5: depth below blanking, floored at zero
    always_comb begin
        avg_raw = m_q.sum_raw[SW-1:AVG_SH];
        avg_scl = m_q.sum_scl[SW-1:AVG_SH];
        full_o  = (m_q.cnt == NSMP);
        h_raw_o = (blank_i > avg_raw) ? (blank_i - avg_raw) : '0;
        h_scl_o = (blank_i > avg_scl) ? (blank_i - avg_scl) : '0;
    end
endmodule

// File: rtl/agc_loop.sv
// Per-line coarse and fine gain update, reference adaptation and hold.
module agc_loop
    import agc_pkg::*;
#(
    parameter int DW       = 10,
    parameter int CW       = 3,
    parameter int GW       = 12,
    parameter int FRAC     = 10,
    parameter int MW       = 8,
    parameter int HYST     = 8,
    parameter int FSH      = 2,
    parameter int RED_STEP = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          line_end_i,
    input  logic          full_i,
    input  logic [DW-1:0] h_raw_i,
    input  logic [DW-1:0] h_scl_i,
    input  logic          white_i,
    input  logic [DW-1:0] tgt_i,
    input  logic          c_auto_i,
    input  logic          f_auto_i,
    input  logic [CW-1:0] c_man_i,
    input  logic [GW-1:0] f_man_i,
    input  logic [MW-1:0] hold_lines_i,
    output logic [CW-1:0] coarse_o,
    output logic [GW-1:0] gain_o,
    output logic          hold_o
);
    localparam logic [CW-1:0] C_INIT = CW'(1 << (CW - 1));
    localparam logic [CW-1:0] C_MAX  = '1;
    localparam logic [GW-1:0] G_UNIT = GW'(1 << FRAC);
    localparam logic [MW-1:0] M_MAX  = '1;
    localparam int            EW     = DW + 2;
    localparam int            SGW    = GW + 2;

    typedef struct packed {
        logic [CW-1:0] coarse;
        logic [GW-1:0] gain;
        logic [DW-1:0] red;
        logic [MW-1:0] miss;
        logic          hold;
        logic          whi;
    } loop_t;

    loop_t s_d, s_q;

    logic [DW-1:0]         red_lim, ref_h, red_cap;
    logic [DW:0]           red_sum;
    logic [MW-1:0]         miss_nx;
    logic                  whi_line;
    step_e                 step;
    logic signed [EW-1:0]  err, delta;
    logic signed [SGW-1:0] delta_w, g_sum;

    always_comb begin
        // R6: reference after reduction, reduction limited to half the target
        red_cap  = tgt_i >> 1;
        red_lim  = (s_q.red > red_cap) ? red_cap : s_q.red;
        ref_h    = tgt_i - red_lim;
        red_sum  = {1'b0, red_lim} + (DW+1)'(RED_STEP);
        whi_line = s_q.whi | white_i;
        miss_nx  = (s_q.miss == M_MAX) ? M_MAX : s_q.miss + 1'b1;

        // R3: hysteresis decision on the raw depth
        if (({1'b0, h_raw_i} + (DW+1)'(HYST)) < {1'b0, ref_h}) begin
            step = STEP_UP;
        end else if ({1'b0, h_raw_i} > ({1'b0, ref_h} + (DW+1)'(HYST))) begin
            step = STEP_DOWN;
        end else begin
            step = STEP_KEEP;
        end

        // R4: shift-based correction from the scaled depth
        err     = $signed({2'b00, ref_h}) - $signed({2'b00, h_scl_i});
        delta   = err >>> FSH;
        delta_w = SGW'(delta);
        g_sum   = $signed({2'b00, s_q.gain}) + delta_w;

        s_d     = s_q;
        s_d.whi = whi_line;
        if (line_end_i) begin
            s_d.whi = 1'b0;
            if (s_q.hold) begin
                // R9: first valid line only re-arms the loop
                if (full_i) begin
                    s_d.hold = 1'b0;
                    s_d.miss = '0;
                end
            end else if (full_i) begin
                s_d.miss = '0;
                if (whi_line) begin
                    s_d.red = (red_sum > {1'b0, red_cap}) ? red_cap : red_sum[DW-1:0];
                end
                if (c_auto_i) begin
                    if (step == STEP_UP && s_q.coarse != C_MAX) begin
                        s_d.coarse = s_q.coarse + 1'b1;
                    end else if (step == STEP_DOWN && s_q.coarse != '0) begin
                        s_d.coarse = s_q.coarse - 1'b1;
                    end
                end
                if (f_auto_i) begin
                    if (g_sum < 0) begin
                        s_d.gain = '0;
                    end else if (g_sum > $signed({2'b00, {GW{1'b1}}})) begin
                        s_d.gain = '1;
                    end else begin
                        s_d.gain = g_sum[GW-1:0];
                    end
                end
            end else begin
                s_d.miss = miss_nx;
                if (miss_nx >= hold_lines_i) begin
                    s_d.hold = 1'b1;
                end
            end
        end
        // R7 / R8: manual values override their stage every cycle
        if (!c_auto_i) begin
            s_d.coarse = c_man_i;
        end
        if (!f_auto_i) begin
            s_d.gain = f_man_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q        <= '0;
            s_q.coarse <= C_INIT;
            s_q.gain   <= G_UNIT;
        end else begin
            s_q <= s_d;
        end
    end

    assign coarse_o = s_q.coarse;
    assign gain_o   = s_q.gain;
    assign hold_o   = s_q.hold;
endmodule

// File: rtl/sync_agc.sv
// Two-stage sync-tip gain controller top.
module sync_agc #(
    parameter int DW       = 10,
    parameter int CW       = 3,
    parameter int GW       = 12,
    parameter int FRAC     = 10,
    parameter int AVG_SH   = 3,
    parameter int MW       = 8,
    parameter int HYST     = 8,
    parameter int FSH      = 2,
    parameter int RED_STEP = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] smp_i,
    input  logic          smp_vld_i,
    input  logic          sync_win_i,
    input  logic          line_end_i,
    input  logic          white_ovr_i,
    input  logic [DW-1:0] blank_lvl_i,
    input  logic [DW-1:0] tgt_height_i,
    input  logic          coarse_auto_i,
    input  logic          fine_auto_i,
    input  logic [CW-1:0] coarse_man_i,
    input  logic [GW-1:0] fine_man_i,
    input  logic [MW-1:0] hold_lines_i,
    output logic [CW-1:0] coarse_o,
    output logic [DW-1:0] smp_o,
    output logic          smp_vld_o,
    output logic [GW-1:0] gain_o,
    output logic          hold_o
);
    typedef struct packed {
        logic [DW-1:0] smp;
        logic          vld;
    } out_t;

    out_t o_d, o_q;

    logic [DW-1:0] scl;
    logic          full;
    logic [DW-1:0] h_raw, h_scl;
    logic [GW-1:0] gain;

    // R10: one gain drives the luma multiplier and the shared output
    agc_scale #(.DW(DW), .GW(GW), .FRAC(FRAC)) u_scale (
        .smp_i  (smp_i),
        .gain_i (gain),
        .scl_o  (scl)
    );

    agc_tip_meter #(.DW(DW), .AVG_SH(AVG_SH)) u_meter (
        .clk        (clk),
        .rst_n      (rst_n),
        .smp_vld_i  (smp_vld_i),
        .win_i      (sync_win_i),
        .line_end_i (line_end_i),
        .raw_i      (smp_i),
        .scl_i      (scl),
        .blank_i    (blank_lvl_i),
        .full_o     (full),
        .h_raw_o    (h_raw),
        .h_scl_o    (h_scl)
    );

    agc_loop #(
        .DW(DW), .CW(CW), .GW(GW), .FRAC(FRAC), .MW(MW),
        .HYST(HYST), .FSH(FSH), .RED_STEP(RED_STEP)
    ) u_loop (
        .clk          (clk),
        .rst_n        (rst_n),
        .line_end_i   (line_end_i),
        .full_i       (full),
        .h_raw_i      (h_raw),
        .h_scl_i      (h_scl),
        .white_i      (white_ovr_i),
        .tgt_i        (tgt_height_i),
        .c_auto_i     (coarse_auto_i),
        .f_auto_i     (fine_auto_i),
        .c_man_i      (coarse_man_i),
        .f_man_i      (fine_man_i),
        .hold_lines_i (hold_lines_i),
        .coarse_o     (coarse_o),
        .gain_o       (gain),
        .hold_o       (hold_o)
    );

    // R2: registered scaled sample
    always_comb begin
        o_d     = o_q;
        o_d.vld = smp_vld_i;
        if (smp_vld_i) begin
            o_d.smp = scl;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            o_q <= '0;
        end else begin
            o_q <= o_d;
        end
    end

    assign smp_o     = o_q.smp;
    assign smp_vld_o = o_q.vld;
    assign gain_o    = gain;
endmodule

// File: rtl/agc_checker.sv
module agc_checker #(
    parameter int CW = 3,
    parameter int GW = 12
) (
    input logic          clk,
    input logic          rst_n,
    input logic          line_end_i,
    input logic          smp_vld_i,
    input logic          coarse_auto_i,
    input logic          fine_auto_i,
    input logic [CW-1:0] coarse_man_i,
    input logic [GW-1:0] fine_man_i,
    input logic [CW-1:0] coarse_o,
    input logic [GW-1:0] gain_o,
    input logic          hold_o,
    input logic          smp_vld_o
);
    p_coarse_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        coarse_auto_i |=> ((coarse_o == $past(coarse_o)) ||
                           (coarse_o == $past(coarse_o) + 1'b1) ||
                           ($past(coarse_o) == coarse_o + 1'b1)));

    p_mid_line_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (coarse_auto_i && fine_auto_i && !line_end_i) |=> ($stable(coarse_o) && $stable(gain_o)));

    p_hold_freeze_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_o && coarse_auto_i && fine_auto_i) |=> ($stable(coarse_o) && $stable(gain_o)));

    p_man_coarse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !coarse_auto_i |=> (coarse_o == $past(coarse_man_i)));

    p_man_fine_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !fine_auto_i |=> (gain_o == $past(fine_man_i)));

    p_vld_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (smp_vld_o == $past(smp_vld_i)));
endmodule

bind sync_agc agc_checker #(.CW(CW), .GW(GW)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .line_end_i    (line_end_i),
    .smp_vld_i     (smp_vld_i),
    .coarse_auto_i (coarse_auto_i),
    .fine_auto_i   (fine_auto_i),
    .coarse_man_i  (coarse_man_i),
    .fine_man_i    (fine_man_i),
    .coarse_o      (coarse_o),
    .gain_o        (gain_o),
    .hold_o        (hold_o),
    .smp_vld_o     (smp_vld_o)
);

// File: tb/sim_sync_agc.sv
`timescale 1ns/1ps
module sim_sync_agc;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [9:0]  smp_i = '0;
    logic        smp_vld_i = 1'b0, sync_win_i = 1'b0, line_end_i = 1'b0, white_ovr_i = 1'b0;
    logic [9:0]  blank_lvl_i = 10'd600, tgt_height_i = 10'd200;
    logic        coarse_auto_i = 1'b1, fine_auto_i = 1'b1;
    logic [2:0]  coarse_man_i = '0;
    logic [11:0] fine_man_i = '0;
    logic [7:0]  hold_lines_i = 8'd3;
    logic [2:0]  coarse_o;
    logic [9:0]  smp_o;
    logic        smp_vld_o;
    logic [11:0] gain_o;
    logic        hold_o;

    int errors = 0, checks = 0;
    string tag = "R1";
    bit done = 0;

    always #4 clk = ~clk;

    sync_agc u0 (.*);

    // behavioural model state
    int m_coarse, m_gain, m_red, m_miss, m_smp, m_vld;
    bit m_hold, m_whi;
    int acc_raw[$], acc_scl[$];

    function automatic int scale(int s, int g);
        int p = (s * g) / 1024;
        return (p > 1023) ? 1023 : p;
    endfunction

    function automatic int depth(int q[$]);
        int sum = 0;
        foreach (q[k]) sum += q[k];
        sum = sum / 8;
        return (blank_lvl_i > sum) ? (int'(blank_lvl_i) - sum) : 0;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_coarse = 4; m_gain = 1024; m_red = 0; m_miss = 0; m_hold = 0; m_whi = 0;
            m_smp = 0; m_vld = 0; acc_raw.delete(); acc_scl.delete();
        end else begin
            int cap, refh, hr, hs, ng, nc, nr, sc;
            bit whi, valid;
            cap  = tgt_height_i / 2;
            refh = int'(tgt_height_i) - ((m_red > cap) ? cap : m_red);
            whi  = m_whi || white_ovr_i;
            sc   = scale(smp_i, m_gain);
            nc = m_coarse; ng = m_gain; nr = m_red;
            if (line_end_i) begin
                valid = (acc_raw.size() == 8);
                hr = depth(acc_raw); hs = depth(acc_scl);
                if (m_hold) begin
                    if (valid) begin m_hold = 0; m_miss = 0; end
                end else if (valid) begin
                    m_miss = 0;
                    if (whi) nr = ((m_red > cap ? cap : m_red) + 16 > cap) ? cap : (m_red > cap ? cap : m_red) + 16;
                    if (coarse_auto_i) begin
                        if (hr + 8 < refh && m_coarse < 7) nc = m_coarse + 1;
                        else if (hr > refh + 8 && m_coarse > 0) nc = m_coarse - 1;
                    end
                    if (fine_auto_i) begin
                        ng = m_gain + ((refh - hs) >>> 2);
                        if (ng < 0) ng = 0;
                        if (ng > 4095) ng = 4095;
                    end
                end else begin
                    m_miss = (m_miss == 255) ? 255 : m_miss + 1;
                    if (m_miss >= hold_lines_i) m_hold = 1;
                end
                acc_raw.delete(); acc_scl.delete();
                m_whi = 0;
            end else begin
                m_whi = whi;
                if (smp_vld_i && sync_win_i && acc_raw.size() < 8) begin
                    acc_raw.push_back(smp_i); acc_scl.push_back(sc);
                end
            end
            if (!coarse_auto_i) nc = coarse_man_i;
            if (!fine_auto_i) ng = fine_man_i;
            m_coarse = nc; m_gain = ng; m_red = nr;
            m_vld = smp_vld_i;
            if (smp_vld_i) m_smp = sc;
        end
    end

    task automatic chk(string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d t=%0t", tag, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (!done) begin
            chk("coarse_o", coarse_o, m_coarse);
            chk("gain_o", gain_o, m_gain);
            chk("smp_o", smp_o, m_smp);
            chk("smp_vld_o", smp_vld_o, m_vld);
            chk("hold_o", hold_o, m_hold);
        end
    end

    // one line of 32 samples; amplitude of the tip follows the coarse code
    task automatic line(int wlen, bit white, bit gaps, int bright);
        for (int i = 0; i < 32; i++) begin
            @(negedge clk);
            smp_vld_i   = !(gaps && (i == 6 || i == 25));
            sync_win_i  = (i >= 4) && (i < 4 + wlen);
            smp_i       = sync_win_i ? 10'(int'(blank_lvl_i) - (50 + 30 * int'(coarse_o)))
                        : (i == 20 ? 10'(bright) : blank_lvl_i);
            white_ovr_i = white && (i == 20 || i == 31);
            line_end_i  = (i == 31);
        end
    endtask

    initial begin
        #200000;
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        tag = "R1";
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        tag = "R3";
        for (int n = 0; n < 6; n++) line(10, 0, 0, 700);
        tag = "R5";
        line(6, 0, 0, 700);
        line(9, 0, 1, 700);
        line(8, 0, 1, 700);
        tag = "R9";
        for (int n = 0; n < 4; n++) line(0, 0, 0, 700);
        line(10, 0, 0, 700);
        line(10, 0, 0, 700);
        tag = "R6";
        for (int n = 0; n < 8; n++) line(10, 1, 0, 900);
        tag = "R4";
        blank_lvl_i = 10'd640;
        for (int n = 0; n < 5; n++) line(10, 0, 0, 800);
        tag = "R7";
        coarse_auto_i = 1'b0; coarse_man_i = 3'd2;
        line(10, 0, 0, 700);
        coarse_man_i = 3'd7;
        line(10, 0, 0, 700);
        coarse_auto_i = 1'b1;
        line(10, 0, 0, 700);
        tag = "R8";
        fine_auto_i = 1'b0; fine_man_i = 12'd2048;
        line(10, 0, 0, 1000);
        fine_man_i = 12'd512;
        line(10, 0, 0, 1000);
        fine_auto_i = 1'b1;
        tag = "R2";
        line(10, 0, 1, 1023);
        tag = "R10";
        for (int n = 0; n < 4; n++) line(10, 0, 0, 700);
        tag = "R11";
        tgt_height_i = 10'd300;
        for (int n = 0; n < 4; n++) line(10, 0, 0, 700);
        repeat (3) @(negedge clk);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule